// File: doc/BRIEF.md
# USB Device Control Endpoint Sequencer

This block follows the phases of a control transfer on endpoint 0 of a USB device controller. The packet layer decodes each token (SETUP, IN or OUT), reports the payload length, and for SETUP packets also gives the request length and the direction bit taken from the command. Firmware answers through single-cycle strobes: acknowledge a received packet, arm a transmit packet, mark the final data packet, request a stall, clear the sent-stall flag, and acknowledge a setup-end event.

For every token the sequencer returns a handshake decision (ACK, NAK, STALL or no handshake). It also keeps the firmware-visible flags, a one-cycle interrupt pulse and the current phase: idle, transmit data phase or receive data phase. It drops setup packets that are not exactly 8 bytes long. It raises setup-end when a token does not fit the current phase. It stalls on its own when the host sends more OUT data than the request allows, or a packet larger than the endpoint maximum. All outputs are registered and show the result of a token or strobe one clock after the cycle in which it was presented.

Top module: `usb_ep0_ctrl_seq`

## Requirements
- R1: After reset, ep0_state is 0 (idle), and rx_ready, tx_ready, setup_end, sent_stall, ep0_irq and hs_valid are all 0.
- R2: tok_kind encodes 1=SETUP, 2=IN, 3=OUT; 0 is ignored. In idle, a SETUP of exactly 8 bytes sets rx_ready, answers hs_code ACK (1) and pulses ep0_irq. A SETUP of any other length leaves rx_ready at 0, answers hs_code 0 (no handshake) and raises no interrupt.
- R3: When firmware acknowledges a setup packet (fw_rx_serviced) and the request length is non-zero and fw_data_end is low, ep0_state becomes 1 (transmit) if the direction bit was 1, and 2 (receive) otherwise. If the request length is zero or fw_data_end is high, the state stays idle and a status stage becomes pending.
- R4: In transmit, an IN token answers ACK (1), clears tx_ready and pulses ep0_irq when tx_ready is set, and answers NAK (2) otherwise. fw_tx_ready is ignored outside the transmit state.
- R5: In transmit, a SETUP or OUT token sets setup_end, pulses ep0_irq, clears tx_ready and returns the state to idle.
- R6: In receive, a SETUP or IN token sets setup_end, pulses ep0_irq and returns the state to idle. An IN token here gets hs_code 0.
- R7: In receive, an OUT token that stays within the request length answers ACK, sets rx_ready and pulses ep0_irq. While rx_ready is still set, an OUT token answers NAK (2).
- R8: In receive, an OUT packet that takes the total received bytes past the request length, or that is longer than the endpoint maximum (64 by default), answers STALL (3), sets sent_stall, pulses ep0_irq and returns to idle.
- R9: In receive, fw_rx_serviced without fw_data_end keeps the receive state for further packets. With fw_data_end it returns to idle with a status stage pending.
- R10: After fw_send_stall, the next token of any kind answers STALL, sets sent_stall, pulses ep0_irq and forces idle. fw_clear_sent_stall clears sent_stall.
- R11: fw_setup_end_serviced clears setup_end, clears tx_ready and forces the state to idle in the next cycle, whatever the current phase.
- R12: While a status stage is pending in idle, an IN token or a zero-length OUT answers ACK and pulses ep0_irq, and the pending status is then cleared. Without a pending status an IN in idle answers NAK.
- R13: ep0_irq is high for exactly one cycle after a cycle that sets one or more flags; several events in the same cycle give one pulse.
- R14: In transmit, an IN that sends a packet armed together with fw_data_end returns the state to idle with a status stage pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | A decoded token is present this cycle |
| tok_kind | input | 2 | 1 SETUP, 2 IN, 3 OUT, 0 ignored |
| tok_len | input | LEN_W | Payload byte count of the SETUP/OUT packet |
| setup_wlen | input | WLEN_W | Request length field of the setup command |
| setup_dir_in | input | 1 | Direction bit of the setup command (1 = device to host) |
| fw_rx_serviced | input | 1 | Firmware acknowledges the received packet |
| fw_tx_ready | input | 1 | Firmware arms a transmit packet |
| fw_data_end | input | 1 | Marks the final data packet of the phase |
| fw_send_stall | input | 1 | Answer the next token with STALL |
| fw_clear_sent_stall | input | 1 | Clear the sent-stall flag |
| fw_setup_end_serviced | input | 1 | Clear setup-end and force idle |
| rx_ready | output | 1 | A received packet waits for firmware |
| tx_ready | output | 1 | A transmit packet is armed |
| setup_end | output | 1 | A token did not fit the current phase |
| sent_stall | output | 1 | A STALL was sent |
| ep0_irq | output | 1 | One-cycle interrupt pulse |
| ep0_state | output | 2 | 0 idle, 1 transmit, 2 receive |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |

## Verification
Because every flag and the phase are registered, a wrong internal phase shows up one clock after the next token: the handshake code comes back as NAK or no handshake where ACK was due, or setup_end rises when it should not. A wrong byte meter stays hidden until the last OUT packet of a phase. It then shows as a missing or early STALL on that packet, so the tests run multi-packet phases up to and past the request length. A stall request that is latched but never used is seen only on the following token, so each stall test presents a token right after the strobe.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } ep0_state_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_SETUP = 2'd1,
    TK_IN    = 2'd2,
    TK_OUT   = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_code_e;
endpackage

// File: rtl/ep0_req_latch.sv
module ep0_req_latch #(
  parameter int LEN_W       = 7,
  parameter int WLEN_W      = 16,
  parameter int SETUP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  tok_len,
  input  logic [WLEN_W-1:0] setup_wlen,
  input  logic              setup_dir_in,
  input  logic              capture,
  output logic              setup_len_ok,
  output logic [WLEN_W-1:0] req_len,
  output logic              req_dir_in,
  output logic              req_len_zero
);
  localparam logic [LEN_W-1:0] SETUP_LEN = LEN_W'(SETUP_BYTES);

  logic [WLEN_W-1:0] len_q, len_n;
  logic              dir_q, dir_n;

  assign setup_len_ok = (tok_len == SETUP_LEN);

  always_comb begin
    len_n = len_q;
    dir_n = dir_q;
    if (capture) begin
      len_n = setup_wlen;
      dir_n = setup_dir_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      dir_q <= 1'b0;
    end else if (capture) begin
      len_q <= len_n;
      dir_q <= dir_n;
    end
  end

  assign req_len      = len_q;
  assign req_dir_in   = dir_q;
  assign req_len_zero = (len_q == '0);

  // R3
  req_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (req_len == $past(setup_wlen)) && (req_dir_in == $past(setup_dir_in)));
endmodule

// File: rtl/ep0_out_meter.sv
module ep0_out_meter #(
  parameter int LEN_W  = 7,
  parameter int WLEN_W = 16,
  parameter int MAXP   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [WLEN_W-1:0] req_len,
  output logic              overrun
);
  localparam int SUM_W = WLEN_W + 1;
  localparam logic [LEN_W-1:0] MAXP_L = LEN_W'(MAXP);

  logic [WLEN_W-1:0] cnt_q, cnt_n;
  logic [SUM_W-1:0]  sum;
  logic              cnt_en;

  assign sum     = {1'b0, cnt_q} + SUM_W'(pkt_len);
  assign overrun = (sum > {1'b0, req_len}) || (pkt_len > MAXP_L);
  assign cnt_en  = clear || add;

  always_comb begin
    cnt_n = cnt_q;
    if (clear)    cnt_n = '0;
    else if (add) cnt_n = sum[WLEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R8
  bytes_within_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= req_len);
endmodule

// File: rtl/ep0_phase_fsm.sv
module ep0_phase_fsm
  import ep0_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  input  tok_kind_e  tok_kind,
  input  logic       tok_len_zero,
  input  logic       setup_len_ok,
  input  logic       req_dir_in,
  input  logic       req_len_zero,
  input  logic       out_overrun,
  input  logic       fw_rx_serviced,
  input  logic       fw_tx_ready,
  input  logic       fw_data_end,
  input  logic       fw_send_stall,
  input  logic       fw_clear_sent_stall,
  input  logic       fw_setup_end_serviced,
  output logic       setup_accept,
  output logic       out_accept,
  output logic       rx_ready,
  output logic       tx_ready,
  output logic       setup_end,
  output logic       sent_stall,
  output logic       ep0_irq,
  output ep0_state_e ep0_state,
  output logic       hs_valid,
  output hs_code_e   hs_code
);
  ep0_state_e st_q, st_n;
  logic rx_q, rx_n, tx_q, tx_n, last_q, last_n;
  logic se_q, se_n, ss_q, ss_n, spend_q, spend_n, stat_q, stat_n;
  logic irq_q, irq_n, hsv_q, hsv_n;
  hs_code_e hs_q, hs_n;

  always_comb begin
    st_n = st_q; rx_n = rx_q; tx_n = tx_q; last_n = last_q;
    se_n = se_q; ss_n = ss_q; spend_n = spend_q; stat_n = stat_q;
    irq_n = 1'b0; hsv_n = 1'b0; hs_n = HS_NONE;
    setup_accept = 1'b0; out_accept = 1'b0;

    // firmware strobes
    if (fw_clear_sent_stall)   ss_n = 1'b0;
    if (fw_setup_end_serviced) se_n = 1'b0;
    if (fw_send_stall)         spend_n = 1'b1;
    if (fw_rx_serviced && rx_q) begin
      rx_n = 1'b0;
      if (st_q == ST_IDLE) begin
        if (fw_data_end || req_len_zero) stat_n = 1'b1;
        else st_n = req_dir_in ? ST_TX : ST_RX;
      end else if (st_q == ST_RX && fw_data_end) begin
        st_n   = ST_IDLE;
        stat_n = 1'b1;
      end
    end
    if (fw_tx_ready && st_q == ST_TX && !tx_q) begin
      tx_n   = 1'b1;
      last_n = fw_data_end;
    end

    // tokens
    if (tok_valid && tok_kind != TK_NONE) begin
      hsv_n = 1'b1;
      if (spend_q) begin
        hs_n = HS_STALL; ss_n = 1'b1; irq_n = 1'b1; spend_n = 1'b0;
        st_n = ST_IDLE; tx_n = 1'b0; last_n = 1'b0; stat_n = 1'b0;
      end else begin
        unique case (tok_kind)
          TK_SETUP: begin
            if (st_q != ST_IDLE) begin
              se_n = 1'b1; irq_n = 1'b1;
            end
            st_n = ST_IDLE; tx_n = 1'b0; last_n = 1'b0; stat_n = 1'b0;
            if (setup_len_ok) begin
              setup_accept = 1'b1; rx_n = 1'b1; hs_n = HS_ACK; irq_n = 1'b1;
            end
          end
          TK_IN: begin
            if (st_q == ST_TX) begin
              if (tx_q) begin
                hs_n = HS_ACK; tx_n = 1'b0; irq_n = 1'b1;
                if (last_q) begin
                  st_n = ST_IDLE; stat_n = 1'b1; last_n = 1'b0;
                end
              end else begin
                hs_n = HS_NAK;
              end
            end else if (st_q == ST_RX) begin
              se_n = 1'b1; irq_n = 1'b1; st_n = ST_IDLE;
            end else if (stat_q) begin
              hs_n = HS_ACK; stat_n = 1'b0; irq_n = 1'b1;
            end else begin
              hs_n = HS_NAK;
            end
          end
          TK_OUT: begin
            if (st_q == ST_RX) begin
              if (rx_q) begin
                hs_n = HS_NAK;
              end else if (out_overrun) begin
                hs_n = HS_STALL; ss_n = 1'b1; irq_n = 1'b1; st_n = ST_IDLE;
              end else begin
                hs_n = HS_ACK; rx_n = 1'b1; out_accept = 1'b1; irq_n = 1'b1;
              end
            end else if (st_q == ST_TX) begin
              se_n = 1'b1; irq_n = 1'b1; st_n = ST_IDLE;
              tx_n = 1'b0; last_n = 1'b0;
            end else if (stat_q && tok_len_zero) begin
              hs_n = HS_ACK; stat_n = 1'b0; irq_n = 1'b1;
            end else begin
              hs_n = HS_NAK;
            end
          end
          default: hs_n = HS_NONE;
        endcase
      end
    end

    // firmware override of the phase
    if (fw_setup_end_serviced) begin
      st_n = ST_IDLE; tx_n = 1'b0; last_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; rx_q <= 1'b0; tx_q <= 1'b0; last_q <= 1'b0;
      se_q <= 1'b0; ss_q <= 1'b0; spend_q <= 1'b0; stat_q <= 1'b0;
      irq_q <= 1'b0; hsv_q <= 1'b0; hs_q <= HS_NONE;
    end else begin
      st_q <= st_n; rx_q <= rx_n; tx_q <= tx_n; last_q <= last_n;
      se_q <= se_n; ss_q <= ss_n; spend_q <= spend_n; stat_q <= stat_n;
      irq_q <= irq_n; hsv_q <= hsv_n; hs_q <= hs_n;
    end
  end

  assign rx_ready   = rx_q;
  assign tx_ready   = tx_q;
  assign setup_end  = se_q;
  assign sent_stall = ss_q;
  assign ep0_irq    = irq_q;
  assign ep0_state  = st_q;
  assign hs_valid   = hsv_q;
  assign hs_code    = hs_q;

  // R4
  tx_only_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_q |-> (st_q == ST_TX));
  // R5
  setup_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(se_q) |-> irq_q);
  // R10
  stall_irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_q) |-> (irq_q && st_q == ST_IDLE));
  // R2
  short_setup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_SETUP && !setup_len_ok && !spend_q && !rx_q)
      |=> (!rx_q && hs_q == HS_NONE));
  // R7
  out_busy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_OUT && st_q == ST_RX && rx_q && !spend_q)
      |=> (hs_q == HS_NAK && rx_q));
  // R11
  se_service_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_setup_end_serviced |=> (st_q == ST_IDLE && !tx_q));
  // R13
  irq_needs_token_or_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> hsv_q);
endmodule

// File: rtl/usb_ep0_ctrl_seq.sv
module usb_ep0_ctrl_seq
  import ep0_seq_pkg::*;
#(
  parameter int LEN_W       = 7,
  parameter int WLEN_W      = 16,
  parameter int MAXP        = 64,
  parameter int SETUP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [LEN_W-1:0]  tok_len,
  input  logic [WLEN_W-1:0] setup_wlen,
  input  logic              setup_dir_in,
  input  logic              fw_rx_serviced,
  input  logic              fw_tx_ready,
  input  logic              fw_data_end,
  input  logic              fw_send_stall,
  input  logic              fw_clear_sent_stall,
  input  logic              fw_setup_end_serviced,
  output logic              rx_ready,
  output logic              tx_ready,
  output logic              setup_end,
  output logic              sent_stall,
  output logic              ep0_irq,
  output logic [1:0]        ep0_state,
  output logic              hs_valid,
  output logic [1:0]        hs_code
);
  logic              setup_accept, out_accept, setup_len_ok;
  logic              req_dir_in, req_len_zero, out_overrun;
  logic [WLEN_W-1:0] req_len;
  ep0_state_e        state_w;
  hs_code_e          hs_w;

  ep0_req_latch #(.LEN_W(LEN_W), .WLEN_W(WLEN_W), .SETUP_BYTES(SETUP_BYTES)) u_req (
    .clk(clk), .rst_n(rst_n), .tok_len(tok_len), .setup_wlen(setup_wlen),
    .setup_dir_in(setup_dir_in), .capture(setup_accept),
    .setup_len_ok(setup_len_ok), .req_len(req_len),
    .req_dir_in(req_dir_in), .req_len_zero(req_len_zero)
  );

  ep0_out_meter #(.LEN_W(LEN_W), .WLEN_W(WLEN_W), .MAXP(MAXP)) u_meter (
    .clk(clk), .rst_n(rst_n), .clear(setup_accept), .add(out_accept),
    .pkt_len(tok_len), .req_len(req_len), .overrun(out_overrun)
  );

  ep0_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid),
    .tok_kind(tok_kind_e'(tok_kind)), .tok_len_zero(tok_len == '0),
    .setup_len_ok(setup_len_ok), .req_dir_in(req_dir_in),
    .req_len_zero(req_len_zero), .out_overrun(out_overrun),
    .fw_rx_serviced(fw_rx_serviced), .fw_tx_ready(fw_tx_ready),
    .fw_data_end(fw_data_end), .fw_send_stall(fw_send_stall),
    .fw_clear_sent_stall(fw_clear_sent_stall),
    .fw_setup_end_serviced(fw_setup_end_serviced),
    .setup_accept(setup_accept), .out_accept(out_accept),
    .rx_ready(rx_ready), .tx_ready(tx_ready), .setup_end(setup_end),
    .sent_stall(sent_stall), .ep0_irq(ep0_irq), .ep0_state(state_w),
    .hs_valid(hs_valid), .hs_code(hs_w)
  );

  assign ep0_state = state_w;
  assign hs_code   = hs_w;
endmodule

// File: tb/usb_ep0_ctrl_seq_test.sv
`timescale 1ns/1ps
module usb_ep0_ctrl_seq_test;
  logic clk = 1'b0;
  logic rst_n;
  logic tok_valid;
  logic [1:0] tok_kind;
  logic [6:0] tok_len;
  logic [15:0] setup_wlen;
  logic setup_dir_in;
  logic fw_rx_serviced, fw_tx_ready, fw_data_end, fw_send_stall;
  logic fw_clear_sent_stall, fw_setup_end_serviced;
  logic rx_ready, tx_ready, setup_end, sent_stall, ep0_irq, hs_valid;
  logic [1:0] ep0_state, hs_code;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  usb_ep0_ctrl_seq uut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_len(tok_len), .setup_wlen(setup_wlen), .setup_dir_in(setup_dir_in),
    .fw_rx_serviced(fw_rx_serviced), .fw_tx_ready(fw_tx_ready),
    .fw_data_end(fw_data_end), .fw_send_stall(fw_send_stall),
    .fw_clear_sent_stall(fw_clear_sent_stall),
    .fw_setup_end_serviced(fw_setup_end_serviced),
    .rx_ready(rx_ready), .tx_ready(tx_ready), .setup_end(setup_end),
    .sent_stall(sent_stall), .ep0_irq(ep0_irq), .ep0_state(ep0_state),
    .hs_valid(hs_valid), .hs_code(hs_code)
  );

  localparam logic [1:0] K_SETUP = 2'd1, K_IN = 2'd2, K_OUT = 2'd3;
  localparam int H_NONE = 0, H_ACK = 1, H_NAK = 2, H_STALL = 3;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    tok_valid = 0; tok_kind = 0; tok_len = 0; setup_wlen = 0; setup_dir_in = 0;
    fw_rx_serviced = 0; fw_tx_ready = 0; fw_data_end = 0; fw_send_stall = 0;
    fw_clear_sent_stall = 0; fw_setup_end_serviced = 0;
  endtask

  task automatic token(input logic [1:0] k, input int len);
    tok_valid = 1; tok_kind = k; tok_len = 7'(len);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic setup(input int len, input int wlen, input logic dir);
    setup_wlen = 16'(wlen); setup_dir_in = dir;
    token(K_SETUP, len);
  endtask

  task automatic fw(input logic rxs, input logic txr, input logic de,
                    input logic ss, input logic css, input logic ses);
    fw_rx_serviced = rxs; fw_tx_ready = txr; fw_data_end = de;
    fw_send_stall = ss; fw_clear_sent_stall = css; fw_setup_end_serviced = ses;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic t_reset();
    chk("R1 state", ep0_state, 0);
    chk("R1 flags", {rx_ready, tx_ready, setup_end, sent_stall}, 0);
    chk("R1 irq/hs", {ep0_irq, hs_valid}, 0);
  endtask

  task automatic t_setup_len_and_status();
    setup(7, 0, 0);
    chk("R2 short setup rx_ready", rx_ready, 0);
    chk("R2 short setup hs", hs_code, H_NONE);
    chk("R2 short setup irq", ep0_irq, 0);
    setup(8, 0, 0);
    chk("R2 good setup rx_ready", rx_ready, 1);
    chk("R2 good setup hs", hs_code, H_ACK);
    chk("R2 good setup irq", ep0_irq, 1);
    fw(1, 0, 1, 0, 0, 0);
    chk("R3 no-data stays idle", ep0_state, 0);
    chk("R3 rx_ready cleared", rx_ready, 0);
    token(K_IN, 0);
    chk("R12 status IN ack", hs_code, H_ACK);
    chk("R12 status irq", ep0_irq, 1);
    token(K_IN, 0);
    chk("R12 no status -> NAK", hs_code, H_NAK);
  endtask

  task automatic t_in_phase();
    fw(0, 1, 0, 0, 0, 0);
    chk("R4 tx_ready ignored in idle", tx_ready, 0);
    setup(8, 16, 1);
    fw(1, 0, 0, 0, 0, 0);
    chk("R3 dir in -> TX", ep0_state, 1);
    token(K_IN, 0);
    chk("R4 IN unarmed NAK", hs_code, H_NAK);
    fw(0, 1, 0, 0, 0, 0);
    chk("R4 armed", tx_ready, 1);
    token(K_IN, 0);
    chk("R4 IN ack", hs_code, H_ACK);
    chk("R4 tx_ready cleared", tx_ready, 0);
    chk("R4 irq", ep0_irq, 1);
    fw(0, 1, 1, 0, 0, 0);
    token(K_IN, 0);
    chk("R14 last IN ack", hs_code, H_ACK);
    chk("R14 back to idle", ep0_state, 0);
    token(K_OUT, 0);
    chk("R12 zero-length OUT status ack", hs_code, H_ACK);
  endtask

  task automatic t_out_phase();
    setup(8, 20, 0);
    fw(1, 0, 0, 0, 0, 0);
    chk("R3 dir out -> RX", ep0_state, 2);
    token(K_OUT, 8);
    chk("R7 OUT ack", hs_code, H_ACK);
    chk("R7 rx_ready", rx_ready, 1);
    chk("R7 irq", ep0_irq, 1);
    token(K_OUT, 8);
    chk("R7 busy NAK", hs_code, H_NAK);
    fw(1, 0, 0, 0, 0, 0);
    chk("R9 stays RX", ep0_state, 2);
    token(K_OUT, 8);
    chk("R7 second OUT ack", hs_code, H_ACK);
    fw(1, 0, 0, 0, 0, 0);
    token(K_OUT, 8);
    chk("R8 overrun STALL", hs_code, H_STALL);
    chk("R8 sent_stall", sent_stall, 1);
    chk("R8 idle", ep0_state, 0);
    fw(0, 0, 0, 0, 1, 0);
    chk("R10 sent_stall cleared", sent_stall, 0);
  endtask

  task automatic t_out_last();
    setup(8, 4, 0);
    fw(1, 0, 0, 0, 0, 0);
    token(K_OUT, 4);
    chk("R8 exact length ok", hs_code, H_ACK);
    fw(1, 0, 1, 0, 0, 0);
    chk("R9 data end -> idle", ep0_state, 0);
    token(K_IN, 0);
    chk("R12 status after OUT phase", hs_code, H_ACK);
  endtask

  task automatic t_maxp();
    setup(8, 200, 0);
    fw(1, 0, 0, 0, 0, 0);
    token(K_OUT, 65);
    chk("R8 packet > max STALL", hs_code, H_STALL);
    chk("R8 idle after max", ep0_state, 0);
    fw(0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_setup_end_tx();
    setup(8, 8, 1);
    fw(1, 0, 0, 0, 0, 0);
    fw(0, 1, 0, 0, 0, 0);
    setup(8, 0, 0);
    chk("R5 setup_end", setup_end, 1);
    chk("R5 idle", ep0_state, 0);
    chk("R5 tx_ready cleared", tx_ready, 0);
    chk("R5 new setup taken", rx_ready, 1);
    chk("R13 irq pulse", ep0_irq, 1);
    @(negedge clk);
    chk("R13 irq one cycle", ep0_irq, 0);
    fw(1, 0, 0, 0, 0, 1);
    chk("R11 setup_end cleared", setup_end, 0);
    token(K_IN, 0);
    setup(8, 8, 0);
    fw(1, 0, 0, 0, 0, 0);
    token(K_OUT, 0);
    fw(1, 0, 0, 0, 0, 0);
    chk("R5 pre: in RX", ep0_state, 2);
  endtask

  task automatic t_setup_end_rx();
    token(K_IN, 0);
    chk("R6 setup_end", setup_end, 1);
    chk("R6 idle", ep0_state, 0);
    chk("R6 no handshake", hs_code, H_NONE);
    fw(0, 0, 0, 0, 0, 1);
    chk("R11 cleared", setup_end, 0);
    setup(8, 8, 1);
    fw(1, 0, 0, 0, 0, 0);
    chk("R11 pre: in TX", ep0_state, 1);
    fw(0, 0, 0, 0, 0, 1);
    chk("R11 forced idle", ep0_state, 0);
  endtask

  task automatic t_send_stall();
    fw(0, 0, 0, 1, 0, 0);
    setup(8, 0, 0);
    chk("R10 STALL", hs_code, H_STALL);
    chk("R10 sent_stall", sent_stall, 1);
    chk("R10 irq", ep0_irq, 1);
    chk("R10 no rx_ready", rx_ready, 0);
    fw(0, 0, 0, 0, 1, 0);
    chk("R10 cleared", sent_stall, 0);
    setup(8, 0, 0);
    chk("R10 stall used once", hs_code, H_ACK);
    fw(1, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setup_len_and_status();
    t_in_phase();
    t_out_phase();
    t_out_last();
    t_maxp();
    t_setup_end_tx();
    t_setup_end_rx();
    t_send_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule